// File: doc/BRIEF.md
# DMA Bus Master Arbitration Sequencer

This block lets an expansion card take over a shared 16-bit asynchronous bus, run one or more word transfers as bus master, and then hand the bus back. The local side presents a word request (address, write data, direction, byte lanes) and holds it until the block pulses a completion or an error flag. On the bus side the block requests the bus, waits for a grant while the previous master is idle, claims ownership in a fixed order, performs the address and data strobe handshake for each word, and releases the bus in the reverse order.

Everything runs on the single system clock. Active-low bus controls are modelled as plain outputs with a separate output-enable (`bus_oe`) that marks when the block drives the shared address, strobe and direction lines. A separate ownership line turns the external bus buffers around. It is taken one clock before grant-acknowledge and dropped one clock after it, so the buffers never fight another driver.

Top module: `dma_arb_seq`

## Requirements
- R1: During and right after reset, bus request, ownership and grant-acknowledge are high, `bus_oe` is low, all strobes are high, and done and error are low.
- R2: With the block idle, a sampled `xfer_valid` drives `bus_br_n` low from the next clock. It goes high again on the clock after `bus_bgack_n` goes low.
- R3: Ownership is taken (`bus_own_n` low) only on the clock after a clock at which grant was low and both the bus address strobe and data acknowledge were high. Otherwise the block keeps waiting with the request asserted.
- R4: `bus_own_n` goes low exactly one clock before `bus_bgack_n` goes low.
- R5: On exit, `bus_bgack_n` goes high exactly one clock before `bus_own_n` goes high.
- R6: Address, direction (`bus_rw` 1 = read, 0 = write) and, for writes, the data and `bus_wdata_oe` are driven for at least one clock before `bus_as_n` falls. While `bus_halt_n` is low, a new cycle does not assert the address strobe.
- R7: Byte lanes use `xfer_be[1]` for the upper strobe and `xfer_be[0]` for the lower strobe. On reads the selected data strobes fall together with the address strobe. On writes they fall one clock later.
- R8: `bus_oe` is high only while `bus_own_n` is low. Every strobe is driven high in the clock before `bus_oe` falls.
- R9: A cycle ends on the clock after data acknowledge is sampled low with halt high. All strobes then go high and `xfer_done` pulses for one clock. Data acknowledge is ignored while halt is low.
- R10: A bus error sampled while waiting ends the cycle. `xfer_err` pulses for one clock with no done pulse, and the bus is released even if `xfer_valid` is still high.
- R11: For a read, `xfer_rdata` holds the bus data sampled on the clock that acknowledged the cycle.
- R12: If `xfer_valid` is still high one clock after a done pulse, the next word starts without releasing grant-acknowledge or ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Local word request, held until done or error |
| xfer_read | input | 1 | 1 = read word, 0 = write word |
| xfer_be | input | 2 | Byte lanes: bit 1 upper, bit 0 lower |
| xfer_addr | input | AW | Word address |
| xfer_wdata | input | DW | Write data |
| xfer_done | output | 1 | One-clock pulse on normal completion |
| xfer_err | output | 1 | One-clock pulse on bus error |
| xfer_rdata | output | DW | Last read data |
| bus_bg_n | input | 1 | Bus grant, active low |
| bus_as_n_in | input | 1 | Observed bus address strobe |
| bus_dtack_n | input | 1 | Data acknowledge, active low |
| bus_halt_n | input | 1 | Halt, active low |
| bus_berr_n | input | 1 | Bus error, active low |
| bus_rdata_in | input | DW | Bus data for reads |
| bus_br_n | output | 1 | Bus request, active low |
| bus_own_n | output | 1 | Ownership / buffer turnaround, active low |
| bus_bgack_n | output | 1 | Grant acknowledge, active low |
| bus_oe | output | 1 | Drive enable for address, strobes and direction |
| bus_as_n | output | 1 | Address strobe |
| bus_uds_n | output | 1 | Upper data strobe |
| bus_lds_n | output | 1 | Lower data strobe |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_wdata_oe | output | 1 | Write data drive enable |

## Verification
Every bus output is a decode of the sequencer state, so it changes on the clock edge that follows the input sample causing it. Request follows a sampled `xfer_valid` by one clock. Ownership follows a qualifying grant by one clock, and grant-acknowledge follows ownership by one more. Done or error follows the acknowledging sample by one clock. The bench models these delays in a behavioural per-cycle reference that advances on the same rising edge as the design. It compares every output at the falling edge, half a cycle after the edge that should have moved it. Inputs are driven one nanosecond after that comparison.

// File: rtl/dma_arb_seq_pkg.sv
`timescale 1ns/1ps
package dma_arb_seq_pkg;
    localparam int DW = 16;
    localparam int NLANE = DW / 8;

    typedef enum logic [3:0] {
        S_IDLE, S_REQ, S_OWN, S_ACK, S_ADDR,
        S_STRB, S_WAIT, S_TERM, S_GAP, S_REL
    } seq_state_e;

    typedef struct packed {
        logic             rd;
        logic [NLANE-1:0] be;
    } xfer_ctl_t;

    typedef struct packed {
        logic br_n;
        logic own_n;
        logic bgack_n;
        logic oe;
        logic as_n;
        logic uds_n;
        logic lds_n;
        logic data_oe;
        logic done;
        logic err;
    } bus_drive_t;

    function automatic logic holds_bus(seq_state_e s);
        return (s != S_IDLE) && (s != S_REQ);
    endfunction

    function automatic logic in_strobe(seq_state_e s);
        return (s == S_ADDR) || (s == S_STRB) || (s == S_WAIT);
    endfunction

    function automatic bus_drive_t drive_of(seq_state_e s, xfer_ctl_t c, logic err_seen);
        bus_drive_t d;
        logic ds_on;
        d.br_n    = !((s == S_REQ) || (s == S_OWN) || (s == S_ACK));
        d.own_n   = !holds_bus(s);
        d.bgack_n = !((s == S_ACK) || in_strobe(s) || (s == S_TERM) || (s == S_GAP));
        d.oe      = holds_bus(s) && (s != S_OWN);
        d.as_n    = !((s == S_STRB) || (s == S_WAIT));
        ds_on     = (s == S_WAIT) || ((s == S_STRB) && c.rd);
        d.uds_n   = !(ds_on && c.be[1]);
        d.lds_n   = !(ds_on && c.be[0]);
        d.data_oe = in_strobe(s) && !c.rd;
        d.done    = (s == S_TERM) && !err_seen;
        d.err     = (s == S_TERM) && err_seen;
        return d;
    endfunction
endpackage

// File: rtl/dma_arb_seq_fsm.sv
`timescale 1ns/1ps
module dma_arb_seq_fsm
    import dma_arb_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_valid,
    input  logic       bg_n,
    input  logic       as_n_in,
    input  logic       dtack_n,
    input  logic       halt_n,
    input  logic       berr_n,
    output seq_state_e state_q,
    output logic       err_q,
    output logic       load,
    output logic       capture
);
    seq_state_e state_d;
    logic       err_d;
    logic       bus_free;

    assign bus_free = !bg_n && as_n_in && dtack_n;

    always_comb begin
        state_d = state_q;
        err_d   = err_q;
        capture = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                err_d = 1'b0;
                if (xfer_valid) state_d = S_REQ;
            end
            S_REQ:  if (bus_free) state_d = S_OWN;
            S_OWN:  state_d = S_ACK;
            S_ACK:  state_d = S_ADDR;
            S_ADDR: if (halt_n) state_d = S_STRB;
            S_STRB: state_d = S_WAIT;
            S_WAIT: begin
                if (!berr_n) begin
                    state_d = S_TERM;
                    err_d   = 1'b1;
                end else if (!dtack_n && halt_n) begin
                    state_d = S_TERM;
                    capture = 1'b1;
                end
            end
            S_TERM: state_d = S_GAP;
            S_GAP:  state_d = (err_q || !xfer_valid) ? S_REL : S_ADDR;
            S_REL:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    assign load = (state_d == S_ADDR) && (state_q != S_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= load ? 1'b0 : err_d;
        end
    end

    // R3
    own_after_free_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OWN) |-> $past(!bg_n && as_n_in && dtack_n));

    // R6
    halt_blocks_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_STRB) |-> $past(halt_n));

    // R9
    done_on_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_TERM && !err_q) |-> $past(!dtack_n && halt_n && berr_n));

    // R10
    err_forces_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_GAP && err_q) |=> (state_q == S_REL));
endmodule

// File: rtl/dma_arb_seq_datapath.sv
`timescale 1ns/1ps
module dma_arb_seq_datapath
    import dma_arb_seq_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          capture,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_wdata,
    input  xfer_ctl_t     in_ctl,
    input  logic [DW-1:0] bus_data,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output xfer_ctl_t     ctl_q,
    output logic [DW-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            wdata_q  <= '0;
            ctl_q.rd <= 1'b1;
            ctl_q.be <= '0;
        end else if (load) begin
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            ctl_q   <= in_ctl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else if (capture && ctl_q.rd) rdata_q <= bus_data;
    end
endmodule

// File: rtl/dma_arb_seq_drive.sv
`timescale 1ns/1ps
module dma_arb_seq_drive
    import dma_arb_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e state_q,
    input  xfer_ctl_t  ctl_q,
    input  logic       err_q,
    output bus_drive_t drv
);
    assign drv = drive_of(state_q, ctl_q, err_q);

    // R4
    own_leads_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.bgack_n) |-> $past(!drv.own_n));

    // R5
    ack_leads_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.own_n) |-> $past(drv.bgack_n));

    // R2
    req_drop_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.br_n) |-> (!drv.bgack_n && $past(!drv.bgack_n)));

    // R8
    oe_needs_own_chk: assert property (@(posedge clk) disable iff (rst)
        drv.oe |-> !drv.own_n);

    // R8
    strobes_high_before_float_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.oe) |-> $past(drv.as_n && drv.uds_n && drv.lds_n));

    // R6
    addr_before_as_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(drv.as_n) |-> $past(drv.oe));

    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(drv.done && drv.err));
endmodule

// File: rtl/dma_arb_seq.sv
`timescale 1ns/1ps
module dma_arb_seq
    import dma_arb_seq_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          xfer_valid,
    input  logic          xfer_read,
    input  logic [1:0]    xfer_be,
    input  logic [AW-1:0] xfer_addr,
    input  logic [DW-1:0] xfer_wdata,
    output logic          xfer_done,
    output logic          xfer_err,
    output logic [DW-1:0] xfer_rdata,
    input  logic          bus_bg_n,
    input  logic          bus_as_n_in,
    input  logic          bus_dtack_n,
    input  logic          bus_halt_n,
    input  logic          bus_berr_n,
    input  logic [DW-1:0] bus_rdata_in,
    output logic          bus_br_n,
    output logic          bus_own_n,
    output logic          bus_bgack_n,
    output logic          bus_oe,
    output logic          bus_as_n,
    output logic          bus_uds_n,
    output logic          bus_lds_n,
    output logic          bus_rw,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe
);
    seq_state_e state_q;
    logic       err_q;
    logic       load;
    logic       capture;
    xfer_ctl_t  in_ctl;
    xfer_ctl_t  ctl_q;
    bus_drive_t drv;

    assign in_ctl.rd = xfer_read;
    assign in_ctl.be = xfer_be;

    dma_arb_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .xfer_valid (xfer_valid),
        .bg_n       (bus_bg_n),
        .as_n_in    (bus_as_n_in),
        .dtack_n    (bus_dtack_n),
        .halt_n     (bus_halt_n),
        .berr_n     (bus_berr_n),
        .state_q    (state_q),
        .err_q      (err_q),
        .load       (load),
        .capture    (capture)
    );

    dma_arb_seq_datapath #(.AW(AW)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .capture  (capture),
        .in_addr  (xfer_addr),
        .in_wdata (xfer_wdata),
        .in_ctl   (in_ctl),
        .bus_data (bus_rdata_in),
        .addr_q   (bus_addr),
        .wdata_q  (bus_wdata),
        .ctl_q    (ctl_q),
        .rdata_q  (xfer_rdata)
    );

    dma_arb_seq_drive u_drv (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .ctl_q   (ctl_q),
        .err_q   (err_q),
        .drv     (drv)
    );

    assign bus_br_n     = drv.br_n;
    assign bus_own_n    = drv.own_n;
    assign bus_bgack_n  = drv.bgack_n;
    assign bus_oe       = drv.oe;
    assign bus_as_n     = drv.as_n;
    assign bus_uds_n    = drv.uds_n;
    assign bus_lds_n    = drv.lds_n;
    assign bus_wdata_oe = drv.data_oe;
    assign bus_rw       = !drv.data_oe;
    assign xfer_done    = drv.done;
    assign xfer_err     = drv.err;
endmodule

// File: tb/dma_arb_seq_tb.sv
`timescale 1ns/1ps
module dma_arb_seq_tb;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam logic [15:0] SCRAMBLE = 16'h5A3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          xfer_valid = 1'b0, xfer_read = 1'b1;
    logic [1:0]    xfer_be = 2'b11;
    logic [AW-1:0] xfer_addr = '0;
    logic [DW-1:0] xfer_wdata = '0;
    logic          xfer_done, xfer_err;
    logic [DW-1:0] xfer_rdata;
    logic          bg_n = 1'b1, as_in_n, dtack_n = 1'b1, halt_n = 1'b1, berr_n = 1'b1;
    logic [DW-1:0] rdata_in;
    logic          br_n, own_n, bgack_n, oe, as_n, uds_n, lds_n, rw, wdata_oe;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata;

    dma_arb_seq #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_read(xfer_read),
        .xfer_be(xfer_be), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
        .xfer_done(xfer_done), .xfer_err(xfer_err), .xfer_rdata(xfer_rdata),
        .bus_bg_n(bg_n), .bus_as_n_in(as_in_n), .bus_dtack_n(dtack_n),
        .bus_halt_n(halt_n), .bus_berr_n(berr_n), .bus_rdata_in(rdata_in),
        .bus_br_n(br_n), .bus_own_n(own_n), .bus_bgack_n(bgack_n), .bus_oe(oe),
        .bus_as_n(as_n), .bus_uds_n(uds_n), .bus_lds_n(lds_n), .bus_rw(rw),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_wdata_oe(wdata_oe)
    );

    int checks = 0, errors = 0;
    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- bus environment ----------------
    int grant_delay = 0, gcnt = 0, slave_lat = 0, scnt = 0, prev_busy = 0;
    bit err_mode = 1'b0;
    assign as_in_n  = (prev_busy == 0);
    assign rdata_in = b_addr[15:0] ^ SCRAMBLE;

    always @(posedge clk) begin
        if (prev_busy > 0) prev_busy <= prev_busy - 1;
        if (!br_n) begin
            if (gcnt >= grant_delay) bg_n <= 1'b0;
            else gcnt <= gcnt + 1;
        end else begin
            bg_n <= 1'b1;
            gcnt <= 0;
        end
        if (oe && !as_n) begin
            if (scnt >= slave_lat) begin
                if (err_mode) berr_n <= 1'b0;
                else dtack_n <= 1'b0;
            end else scnt <= scnt + 1;
        end else begin
            dtack_n <= 1'b1;
            berr_n  <= 1'b1;
            scnt    <= 0;
        end
    end

    // ---------------- reference model ----------------
    localparam int M_IDLE = 0, M_REQ = 1, M_OWN = 2, M_ACK = 3, M_ADDR = 4,
                   M_STRB = 5, M_WAIT = 6, M_TERM = 7, M_GAP = 8, M_REL = 9;
    int            ph = M_IDLE;
    bit            m_err = 0, m_rd = 1;
    logic [1:0]    m_be = 2'b00;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_wdata = '0, m_rdata = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph <= M_IDLE; m_err <= 0; m_rdata <= '0;
        end else begin
            if ((ph == M_ACK) || (ph == M_GAP && !m_err && xfer_valid)) begin
                m_addr <= xfer_addr; m_wdata <= xfer_wdata;
                m_rd <= xfer_read; m_be <= xfer_be; m_err <= 0;
            end
            case (ph)
                M_IDLE: begin m_err <= 0; if (xfer_valid) ph <= M_REQ; end
                M_REQ:  if (!bg_n && as_in_n && dtack_n) ph <= M_OWN;
                M_OWN:  ph <= M_ACK;
                M_ACK:  ph <= M_ADDR;
                M_ADDR: if (halt_n) ph <= M_STRB;
                M_STRB: ph <= M_WAIT;
                M_WAIT: if (!berr_n) begin ph <= M_TERM; m_err <= 1; end
                        else if (!dtack_n && halt_n) begin
                            ph <= M_TERM;
                            if (m_rd) m_rdata <= m_addr[15:0] ^ SCRAMBLE;
                        end
                M_TERM: ph <= M_GAP;
                M_GAP:  ph <= (m_err || !xfer_valid) ? M_REL : M_ADDR;
                default: ph <= M_IDLE;
            endcase
        end
    end

    bit started = 0;
    always @(posedge clk) started <= 1;

    always @(negedge clk) begin
        if (started) begin
            bit xfer_on, ds;
            xfer_on = (ph == M_ADDR || ph == M_STRB || ph == M_WAIT);
            ds = (ph == M_WAIT) || (ph == M_STRB && m_rd);
            chk("R2", "br_n", br_n, !(ph == M_REQ || ph == M_OWN || ph == M_ACK));
            chk("R3,R4", "own_n", own_n, (ph == M_IDLE || ph == M_REQ));
            chk("R4,R5", "bgack_n", bgack_n, !(ph == M_ACK || xfer_on || ph == M_TERM || ph == M_GAP));
            chk("R8", "oe", oe, !(ph == M_IDLE || ph == M_REQ || ph == M_OWN));
            chk("R6", "as_n", as_n, !(ph == M_STRB || ph == M_WAIT));
            chk("R7", "uds_n", uds_n, !(ds && m_be[1]));
            chk("R7", "lds_n", lds_n, !(ds && m_be[0]));
            chk("R6", "wdata_oe", wdata_oe, xfer_on && !m_rd);
            chk("R6", "rw", rw, !(xfer_on && !m_rd));
            if (xfer_on) chk("R6", "addr", b_addr, m_addr);
            if (xfer_on && !m_rd) chk("R6", "wdata", b_wdata, m_wdata);
            chk("R9", "done", xfer_done, (ph == M_TERM) && !m_err);
            chk("R10", "err", xfer_err, (ph == M_TERM) && m_err);
            chk("R11", "rdata", xfer_rdata, m_rdata);
        end
    end

    int bgack_rises = 0;
    logic bgack_prev = 1'b1;
    always @(posedge clk) begin
        bgack_prev <= bgack_n;
        if (bgack_n && !bgack_prev) bgack_rises <= bgack_rises + 1;
    end

    // ---------------- stimulus ----------------
    task automatic word(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rd,
                        input logic [1:0] be, input bit chain, input int linger);
        xfer_valid = 1'b1; xfer_addr = a; xfer_wdata = d; xfer_read = rd; xfer_be = be;
        forever begin
            @(negedge clk); #1;
            if (xfer_done || xfer_err) break;
        end
        repeat (linger) @(negedge clk);
        #1;
        if (!chain) xfer_valid = 1'b0;
    endtask

    task automatic settle();
        forever begin
            @(negedge clk); #1;
            if (own_n) break;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs straight out of reset
        chk("R1", "idle br/own/bgack/oe", {br_n, own_n, bgack_n, oe}, 4'b1110);
        chk("R1", "idle strobes/done/err", {as_n, uds_n, lds_n, xfer_done, xfer_err}, 5'b11100);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        #1;

        // R11 R7: read, both lanes, grant delayed
        grant_delay = 2; slave_lat = 1;
        word(23'h012345, 16'h0, 1'b1, 2'b11, 0, 0);
        settle();

        // R3: previous master still busy; write upper lane only
        prev_busy = 5; grant_delay = 0; slave_lat = 0;
        word(23'h00BEEF, 16'hC0DE, 1'b0, 2'b10, 0, 0);
        settle();

        // R12: back-to-back words under one tenure
        bgack_rises = 0;
        word(23'h000100, 16'h0, 1'b1, 2'b01, 1, 0);
        word(23'h000202, 16'h1111, 1'b0, 2'b01, 1, 0);
        chk("R12", "bgack held between words", {bgack_n, 32'(bgack_rises)} != 0 ? bgack_rises : 0, 0);
        chk("R12", "own held between words", own_n, 1'b0);
        word(23'h000304, 16'h0, 1'b1, 2'b11, 0, 0);
        settle();

        // R6: halt blocks the start of a cycle
        halt_n = 1'b0;
        xfer_valid = 1'b1; xfer_addr = 23'h0004AA; xfer_read = 1'b1; xfer_be = 2'b11;
        forever begin @(negedge clk); #1; if (!bgack_n) break; end
        repeat (4) @(negedge clk);
        chk("R6", "no AS while halted", as_n, 1'b1);
        #1 halt_n = 1'b1;
        forever begin @(negedge clk); #1; if (xfer_done) break; end
        xfer_valid = 1'b0;
        settle();

        // R9: acknowledge ignored while halt is low
        xfer_valid = 1'b1; xfer_addr = 23'h0005C0; xfer_read = 1'b0; xfer_wdata = 16'h7E57; xfer_be = 2'b11;
        forever begin @(negedge clk); #1; if (!as_n) break; end
        halt_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", "no done while halted", xfer_done, 1'b0);
        #1 halt_n = 1'b1;
        forever begin @(negedge clk); #1; if (xfer_done) break; end
        xfer_valid = 1'b0;
        settle();

        // R10: bus error with valid kept high through the gap
        err_mode = 1'b1; slave_lat = 2;
        word(23'h0006F0, 16'h0, 1'b1, 2'b11, 1, 2);
        chk("R10", "bus released after error", bgack_n, 1'b1);
        xfer_valid = 1'b0;
        err_mode = 1'b0;
        settle();
        chk("R10", "idle after error", {br_n, own_n, oe}, 3'b110);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule